// File: doc/BRIEF.md
# GPIO and Peripheral Pin Multiplexer

This block sits between two banks of sixteen I/O pins and two kinds of on-chip users: a general purpose I/O controller and a set of peripheral functions (a NAND flash port, an SPI port and a UART receiver). A per-bank mode register picks the owner of each pin. If the peripheral owns a pin, it drives the pin's output value and output enable. If the GPIO logic owns it, the GPIO data-out and direction registers drive them instead.

The pin levels always reach a pair of input-data registers through a two-flop synchronizer, whichever owner a pin has. A pin handed to GPIO also cuts its peripheral off from the pad. The peripheral input that the pin fed is held at a fixed idle level, so the peripheral sees a quiet, inactive line rather than whatever the pad happens to be doing.

Software reaches the block through a small register port. It has a single-cycle write strobe and a combinational read path that returns the addressed register in the same cycle.

Top module: `pinmux_top`

## Requirements
- R1: After reset both mode registers read 16'hFFFF, so every pin belongs to its peripheral. Both data-out registers and both direction registers read 16'h0000.
- R2: While a pin's mode bit is 1, its pad output and pad output enable equal that pin's peripheral output and peripheral enable in the same cycle.
- R3: While a pin's mode bit is 0, its pad output equals the matching data-out register bit and its pad output enable equals the matching direction register bit (1 = drive).
- R4: The input-data register of a bank shows the pad levels sampled two rising clock edges earlier, in either mode. It reads 0 until two edges have passed since reset.
- R5: While a pin's mode bit is 1, the peripheral input fed from that pin equals the pad level in the same cycle.
- R6: While any of bank 0 pins 7 down to 0 is in GPIO mode, the matching NAND data input bit is held at 0.
- R7: While bank 0 pin 8 is in GPIO mode, the NAND ready input is held at 1.
- R8: While any of bank 1 pins 0 to 3 is in GPIO mode, the matching SPI input (select, clock, MISO, MOSI) is held at 1.
- R9: While bank 1 pin 5 is in GPIO mode, the UART receive input is held at 1.
- R10: While any other pin is in GPIO mode, its peripheral input is held at 0.
- R11: A write with the strobe high updates the addressed register at the next rising edge. Writes to an input-data address change nothing. Reads return the addressed register combinationally.
- R12: Address bits [2:1] choose the register kind and bit 0 chooses the bank. The kinds are 0 = mode, 1 = input data, 2 = data out and 3 = direction. Flat pin vectors put bank b pin p at bit 16*b+p.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address: kind in [2:1], bank in [0] |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the addressed register |
| pad_in | input | 32 | Pin levels from the pads |
| pad_out | output | 32 | Output value to the pads |
| pad_oe | output | 32 | Output enable to the pads |
| per_out | input | 32 | Peripheral output value for each pin |
| per_oe | input | 32 | Peripheral output enable for each pin |
| per_in | output | 32 | Peripheral input for each pin, idle level when under GPIO |

## Verification
The assertions check the following on every cycle:
- the output routing in both modes;
- pass-through versus idle level on every peripheral input;
- the two-edge delay of the input-data registers;
- that a write lands one edge later;
- that an input-data address write leaves the writable registers alone.

Only the bench's scenarios can show three things:
- the reset values;
- the address decoding seen through reads;
- the bit positions of each fixed idle level across mixed mode patterns, which it compares against its own reference model on every clock.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;

    // register kind, taken from the upper address bits
    typedef enum logic [1:0] {
        KIND_MODE  = 2'd0,
        KIND_IDATA = 2'd1,
        KIND_ODATA = 2'd2,
        KIND_DIR   = 2'd3
    } reg_kind_e;

    localparam int KIND_W = 2;

endpackage

// File: rtl/pinmux_sync.sv
module pinmux_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= async_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/pinmux_regs.sv
module pinmux_regs
    import pinmux_pkg::*;
#(
    parameter int BANKS  = 2,
    parameter int BANK_W = 16,
    parameter int BSEL_W = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  reg_kind_e               kind,
    input  logic [BSEL_W-1:0]       bank,
    input  logic [BANK_W-1:0]       wdata,
    input  logic [BANKS*BANK_W-1:0] idata,
    output logic [BANK_W-1:0]       rdata,
    output logic [BANKS*BANK_W-1:0] mode_q,
    output logic [BANKS*BANK_W-1:0] odata_q,
    output logic [BANKS*BANK_W-1:0] dir_q
);

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic hit;
        assign hit = we && (int'(bank) == b);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mode_q [b*BANK_W +: BANK_W] <= '1;
                odata_q[b*BANK_W +: BANK_W] <= '0;
                dir_q  [b*BANK_W +: BANK_W] <= '0;
            end else if (hit) begin
                unique case (kind)
                    KIND_MODE:  mode_q [b*BANK_W +: BANK_W] <= wdata;
                    KIND_ODATA: odata_q[b*BANK_W +: BANK_W] <= wdata;
                    KIND_DIR:   dir_q  [b*BANK_W +: BANK_W] <= wdata;
                    default:    ;   // input data is read-only
                endcase
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (int'(bank) < BANKS) begin
            unique case (kind)
                KIND_MODE:  rdata = mode_q [int'(bank)*BANK_W +: BANK_W];
                KIND_IDATA: rdata = idata  [int'(bank)*BANK_W +: BANK_W];
                KIND_ODATA: rdata = odata_q[int'(bank)*BANK_W +: BANK_W];
                KIND_DIR:   rdata = dir_q  [int'(bank)*BANK_W +: BANK_W];
                default:    rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/pinmux_route.sv
module pinmux_route #(
    parameter int                PINS       = 32,
    parameter logic [PINS-1:0]   IDLE_LEVEL = '0
) (
    input  logic [PINS-1:0] mode,
    input  logic [PINS-1:0] odata,
    input  logic [PINS-1:0] dir,
    input  logic [PINS-1:0] pad_in,
    input  logic [PINS-1:0] per_out,
    input  logic [PINS-1:0] per_oe,
    output logic [PINS-1:0] pad_out,
    output logic [PINS-1:0] pad_oe,
    output logic [PINS-1:0] per_in
);

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        // mode 1: peripheral owns the pin, mode 0: GPIO owns it
        assign pad_out[i] = mode[i] ? per_out[i] : odata[i];
        assign pad_oe[i]  = mode[i] ? per_oe[i]  : dir[i];
        assign per_in[i]  = mode[i] ? pad_in[i]  : IDLE_LEVEL[i];
    end

endmodule

// File: rtl/pinmux_top.sv
module pinmux_top
    import pinmux_pkg::*;
#(
    parameter int BANKS  = 2,
    parameter int BANK_W = 16,
    parameter int SYNC_STAGES = 2,
    localparam int BSEL_W = (BANKS > 1) ? $clog2(BANKS) : 1,
    localparam int ADDR_W = KIND_W + BSEL_W,
    localparam int PINS   = BANKS * BANK_W,
    // idle levels: bank0 NAND ready at pin 8, bank1 SPI pins 0..3 and UART rx pin 5
    parameter logic [PINS-1:0] IDLE_LEVEL = PINS'(32'h002F_0100)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BANK_W-1:0] reg_wdata,
    output logic [BANK_W-1:0] reg_rdata,
    input  logic [PINS-1:0]   pad_in,
    output logic [PINS-1:0]   pad_out,
    output logic [PINS-1:0]   pad_oe,
    input  logic [PINS-1:0]   per_out,
    input  logic [PINS-1:0]   per_oe,
    output logic [PINS-1:0]   per_in
);

    reg_kind_e         acc_kind;
    logic [BSEL_W-1:0] acc_bank;
    logic [PINS-1:0]   mode_q;
    logic [PINS-1:0]   odata_q;
    logic [PINS-1:0]   dir_q;
    logic [PINS-1:0]   idata_q;

    assign acc_kind = reg_kind_e'(reg_addr[ADDR_W-1 -: KIND_W]);
    assign acc_bank = reg_addr[BSEL_W-1:0];

    pinmux_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (idata_q)
    );

    pinmux_regs #(.BANKS(BANKS), .BANK_W(BANK_W), .BSEL_W(BSEL_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (reg_we),
        .kind    (acc_kind),
        .bank    (acc_bank),
        .wdata   (reg_wdata),
        .idata   (idata_q),
        .rdata   (reg_rdata),
        .mode_q  (mode_q),
        .odata_q (odata_q),
        .dir_q   (dir_q)
    );

    pinmux_route #(.PINS(PINS), .IDLE_LEVEL(IDLE_LEVEL)) u_route (
        .mode    (mode_q),
        .odata   (odata_q),
        .dir     (dir_q),
        .pad_in  (pad_in),
        .per_out (per_out),
        .per_oe  (per_oe),
        .pad_out (pad_out),
        .pad_oe  (pad_oe),
        .per_in  (per_in)
    );

endmodule

// File: rtl/pinmux_chk.sv
module pinmux_chk #(
    parameter int PINS = 32,
    parameter int BANK_W = 16,
    parameter int ADDR_W = 3,
    parameter logic [PINS-1:0] IDLE_LEVEL = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [BANK_W-1:0] reg_wdata,
    input logic [PINS-1:0]   pad_in,
    input logic [PINS-1:0]   pad_out,
    input logic [PINS-1:0]   pad_oe,
    input logic [PINS-1:0]   per_out,
    input logic [PINS-1:0]   per_oe,
    input logic [PINS-1:0]   per_in,
    input logic [PINS-1:0]   mode_q,
    input logic [PINS-1:0]   odata_q,
    input logic [PINS-1:0]   dir_q,
    input logic [PINS-1:0]   idata_q
);

    logic [1:0] edges;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          edges <= '0;
        else if (edges != 2) edges <= edges + 2'd1;
    end

    assert_periph_route_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (((pad_out ^ per_out) | (pad_oe ^ per_oe)) & mode_q) == '0);

    assert_gpio_route_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (((pad_out ^ odata_q) | (pad_oe ^ dir_q)) & ~mode_q) == '0);

    assert_idata_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (edges == 2) |-> (idata_q == $past(pad_in, 2)));

    assert_pass_through_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((per_in ^ pad_in) & mode_q) == '0);

    assert_idle_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((per_in ^ IDLE_LEVEL) & ~mode_q) == '0);

    assert_mode0_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 3'd0) |=> (mode_q[BANK_W-1:0] == $past(reg_wdata)));

    assert_idata_readonly_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr[2:1] == 2'd1) |=> ($stable(mode_q) && $stable(odata_q) && $stable(dir_q)));

endmodule

bind pinmux_top pinmux_chk #(
    .PINS(PINS), .BANK_W(BANK_W), .ADDR_W(ADDR_W), .IDLE_LEVEL(IDLE_LEVEL)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .per_out   (per_out),
    .per_oe    (per_oe),
    .per_in    (per_in),
    .mode_q    (mode_q),
    .odata_q   (odata_q),
    .dir_q     (dir_q),
    .idata_q   (idata_q)
);

// File: tb/pinmux_top_test.sv
module pinmux_top_test;

    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;
    logic [31:0] per_out = '0;
    logic [31:0] per_oe = '0;
    logic [31:0] per_in;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(PERIOD/2) clk = ~clk;

    pinmux_top uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .per_out(per_out),
        .per_oe(per_oe), .per_in(per_in)
    );

    // reference model
    bit [31:0] m_mode, m_od, m_dir;
    bit [31:0] hist[$];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 32'hFFFF_FFFF; m_od = 0; m_dir = 0;
            hist.delete();
        end else begin
            hist.push_back(pad_in);
            if (hist.size() > 2) void'(hist.pop_front());
            if (reg_we) begin
                int b;
                b = int'(reg_addr[0]);
                case (reg_addr[2:1])
                    2'd0: m_mode[b*16 +: 16] = reg_wdata;
                    2'd2: m_od[b*16 +: 16]   = reg_wdata;
                    2'd3: m_dir[b*16 +: 16]  = reg_wdata;
                    default: ;
                endcase
            end
        end
    end

    function automatic bit [31:0] m_idata();
        return (hist.size() == 2) ? hist[0] : 32'h0;
    endfunction

    function automatic bit [31:0] m_idle();
        bit [31:0] v = 0;
        v[8] = 1;                       // NAND ready
        for (int i = 16; i < 20; i++) v[i] = 1;  // SPI select/clock/MISO/MOSI
        v[21] = 1;                      // UART rx
        return v;
    endfunction

    function automatic bit [15:0] m_read(bit [2:0] a);
        int b = int'(a[0]);
        case (a[2:1])
            2'd0: return m_mode[b*16 +: 16];
            2'd1: return m_idata() >> (b*16);
            2'd2: return m_od[b*16 +: 16];
            default: return m_dir[b*16 +: 16];
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        bit [31:0] ep_in, idle;
        idle  = m_idle();
        ep_in = (pad_in & m_mode) | (idle & ~m_mode);
        chk("R2 pad_out", pad_out & m_mode, per_out & m_mode);
        chk("R2 pad_oe",  pad_oe  & m_mode, per_oe  & m_mode);
        chk("R3 pad_out", pad_out & ~m_mode, m_od  & ~m_mode);
        chk("R3 pad_oe",  pad_oe  & ~m_mode, m_dir & ~m_mode);
        chk("R5 per_in",  per_in & m_mode, ep_in & m_mode);
        chk("R6 nand data", per_in & ~m_mode & 32'h0000_00FF, 32'h0);
        chk("R7 nand ready", per_in & ~m_mode & 32'h0000_0100, ~m_mode & 32'h0000_0100);
        chk("R8 spi", per_in & ~m_mode & 32'h000F_0000, ~m_mode & 32'h000F_0000);
        chk("R9 uart rx", per_in & ~m_mode & 32'h0020_0000, ~m_mode & 32'h0020_0000);
        chk("R10 other", per_in & ~m_mode & 32'hFFD0_FE00, 32'h0);
        if (reg_addr[2:1] == 2'd1) chk("R4 idata read", {16'h0, reg_rdata}, {16'h0, m_read(reg_addr)});
        else                       chk("R11/R12 read", {16'h0, reg_rdata}, {16'h0, m_read(reg_addr)});
    endtask

    task automatic step(bit we, bit [2:0] a, bit [15:0] wd, bit [31:0] pi, bit [31:0] po, bit [31:0] pe);
        @(negedge clk);
        reg_we = we; reg_addr = a; reg_wdata = wd;
        pad_in = pi; per_out = po; per_oe = pe;
        #1 compare_all();
    endtask

    task automatic idle_step(bit [2:0] a);
        step(0, a, 16'h0, $urandom, $urandom, $urandom);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1 reset values, read through the R12 address map
        for (int a = 0; a < 8; a++) begin
            @(negedge clk); reg_addr = 3'(a);
            #1;
            if (a[2:1] != 1)
                chk("R1 reset value", {16'h0, reg_rdata},
                    {16'h0, (a[2:1] == 0) ? 16'hFFFF : 16'h0000});
            compare_all();
        end
        // peripheral mode with varied pads
        for (int i = 0; i < 20; i++) idle_step(3'(i));
        // all pins to GPIO
        step(1, 3'd0, 16'h0000, $urandom, $urandom, $urandom);
        step(1, 3'd1, 16'h0000, $urandom, $urandom, $urandom);
        step(1, 3'd4, 16'hA5C3, $urandom, $urandom, $urandom);
        step(1, 3'd7, 16'h0F0F, $urandom, $urandom, $urandom);
        for (int i = 0; i < 20; i++) idle_step(3'(i));
        // pads all ones then zeros while under GPIO: idle levels must not move
        for (int i = 0; i < 8; i++) step(0, 3'(i), 0, 32'hFFFF_FFFF, '1, '1);
        for (int i = 0; i < 8; i++) step(0, 3'(i), 0, 32'h0, '0, '0);
        // writes to input-data addresses are ignored (R11)
        step(1, 3'd2, 16'h1234, $urandom, $urandom, $urandom);
        step(1, 3'd3, 16'hFFFF, $urandom, $urandom, $urandom);
        for (int i = 0; i < 8; i++) idle_step(3'(i));
        // mixed random traffic
        for (int i = 0; i < 400; i++)
            step(($urandom % 3) == 0, 3'($urandom), 16'($urandom), $urandom, $urandom, $urandom);
        // reset mid-run restores R1
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        for (int i = 0; i < 8; i++) idle_step(3'(i));
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule